// File: doc/BRIEF.md
# Byte-Framed Serial Slave Port with Idle-Timeout Resynchronisation

This block is the serial front end of a register-configured converter. A free-running system clock oversamples the serial clock, the active-low select and the data-in pin through two-stage synchronizers. Eight rising edges of the serial clock make one byte, received most significant bit first, and the byte goes to a downstream command decoder with a one-cycle strobe. The decoder hands the block a response byte, which goes out on the data-out pin one bit per falling edge of the serial clock. Traffic is half-duplex and always framed on whole bytes.

The host may run the link with four wires, or with three by tying select low for good. In the three-wire case nothing marks the start of a frame, so one spurious clock edge would leave every later byte misaligned. To recover, the block counts system clocks while the serial clock sits low. When the count wraps it clears the framing, and it repeats this at every further wrap. Any high sample of the serial clock clears the count, so a host that parks the clock high never sees an automatic reset. Framing also clears while select is high and during the asynchronous external reset.

A small state machine tracks the framing. It has three states:
- `PS_DESEL`: select is high, and the output enable is off.
- `PS_ARMED`: selected, waiting on a byte boundary.
- `PS_SHIFTING`: part of a byte has arrived.

Its transitions are:
- DESEL→ARMED: synchronized select is seen low.
- ARMED→SHIFTING: the first rising edge of a byte.
- SHIFTING→ARMED: the eighth rising edge, or an idle timeout.
- ARMED or SHIFTING→DESEL: synchronized select is seen high.

Top module: `spi_idle_resync_slave`

## Requirements
- R1: Each rising edge of `sclk_pin` samples `din_pin`. After eight such samples while selected, `rx_byte` holds them with the first-sampled bit in bit 7.
- R2: `rx_valid` is high for exactly one system-clock cycle per completed byte, and stays low at every other time.
- R3: While `cs_n_pin` is high, the bit count is held at zero and serial clock edges are ignored. No byte is reported, and a byte cut short by select going high is discarded.
- R4: `dout_oe` is the inverse of the synchronized `cs_n_pin`. It is 1 while selected, including when select is held low permanently.
- R5: A one-cycle `tx_load` while selected captures `tx_byte`. Each later falling edge of `sclk_pin` moves the next bit to `dout`, MSB first, with bit 7 at the first falling edge. `dout` changes at no other time except a framing clear or reset, which drive it to 0. A load takes priority over a falling edge in the same cycle.
- R6: While `sclk_pin` is sampled low for 2^`TIMEOUT_W` consecutive system clocks, the framing clears. The clear drops the partial byte, zeroes the response shifter and sets `dout` to 0. It repeats at every further 2^`TIMEOUT_W` interval of unbroken low. A spurious clock pulse therefore misaligns bytes only until the next such idle.
- R7: Any high sample of `sclk_pin` clears the idle count, so `sclk_pin` held high for any length of time leaves a partial byte intact.
- R8: Pulling `rst_n` low returns the block asynchronously to its reset state, with `rx_valid`, `dout` and `dout_oe` at 0, and discards any partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset / power-down |
| sclk_pin | input | 1 | Serial clock from the host, asynchronous |
| cs_n_pin | input | 1 | Active-low select from the host, asynchronous |
| din_pin | input | 1 | Serial data from the host, asynchronous |
| dout | output | 1 | Serial response data |
| dout_oe | output | 1 | Output enable for a tri-state data-out pad |
| rx_valid | output | 1 | One-cycle strobe: a received byte is ready |
| rx_byte | output | BYTE_W | Last received byte |
| tx_load | input | 1 | Capture `tx_byte` as the next response |
| tx_byte | input | BYTE_W | Response byte from the decoder |

## Verification
The assertions assume that the serial clock is slow enough, relative to `clk`, for every level to be sampled at least twice. They also assume that select and `tx_load` never change in the same few cycles as a serial clock edge, so no edge falls in the cycle where the state machine leaves `PS_DESEL`. The stimulus holds every serial clock phase for four system clocks. It moves select, reset and `tx_load` only while the serial clock is quiet. The one deliberate violation of framing is a single-cycle clock glitch, and that is still wide enough to be sampled.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
    typedef enum logic [1:0] {
        PS_DESEL    = 2'd0,
        PS_ARMED    = 2'd1,
        PS_SHIFTING = 2'd2
    } port_state_e;
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= {2{RST_VAL[i]}};
            else        stage <= {stage[0], async_in[i]};
        end
        assign sync_out[i] = stage[1];
    end
endmodule

// File: rtl/spi_rs_idle_timer.sv
module spi_rs_idle_timer #(
    parameter int CNT_W = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_lvl,
    output logic timeout
);
    logic [CNT_W-1:0] low_cnt;

    // Wrap of the low-level count marks one full idle interval.
    assign timeout = !sclk_lvl && (&low_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_cnt <= '0;
        else if (sclk_lvl) low_cnt <= '0;
        else               low_cnt <= low_cnt + 1'b1;
    end
endmodule

// File: rtl/spi_idle_resync_slave.sv
module spi_idle_resync_slave
    import spi_rs_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int TIMEOUT_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_pin,
    input  logic              cs_n_pin,
    input  logic              din_pin,
    output logic              dout,
    output logic              dout_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte
);
    localparam int            BCW  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [BCW-1:0] LAST = BCW'(BYTE_W - 1);

    logic [2:0]        pins_sync;
    logic              s_sclk, s_cs_n, s_din, sclk_prev;
    logic              sclk_rise, sclk_fall, tmo, frame_clr;
    logic              take_bit, byte_done, at_boundary;
    logic [BCW-1:0]    bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    port_state_e       state, state_nxt;

    spi_rs_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({din_pin, cs_n_pin, sclk_pin}),
        .sync_out (pins_sync)
    );
    assign s_sclk = pins_sync[0];
    assign s_cs_n = pins_sync[1];
    assign s_din  = pins_sync[2];

    spi_rs_idle_timer #(.CNT_W(TIMEOUT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_lvl (s_sclk),
        .timeout  (tmo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= s_sclk;
    end

    assign sclk_rise   = s_sclk && !sclk_prev;
    assign sclk_fall   = !s_sclk && sclk_prev;
    assign frame_clr   = s_cs_n || tmo;
    assign at_boundary = (bit_cnt == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_DESEL;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_DESEL:    if (!s_cs_n) state_nxt = PS_ARMED;
            PS_ARMED: begin
                if (s_cs_n)         state_nxt = PS_DESEL;
                else if (sclk_rise) state_nxt = PS_SHIFTING;
            end
            PS_SHIFTING: begin
                if (s_cs_n)                              state_nxt = PS_DESEL;
                else if (tmo)                            state_nxt = PS_ARMED;
                else if (sclk_rise && bit_cnt == LAST)   state_nxt = PS_ARMED;
            end
            default:     state_nxt = PS_DESEL;
        endcase
    end

    // Output decode of the state machine
    always_comb begin
        take_bit  = (state != PS_DESEL) && !frame_clr && sclk_rise;
        byte_done = take_bit && (state == PS_SHIFTING) && (bit_cnt == LAST);
    end

    // Receive framing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= byte_done;
            if (byte_done) rx_byte <= {rx_sh[BYTE_W-2:0], s_din};
            if (frame_clr) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
            end else if (take_bit) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], s_din};
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
            end
        end
    end

    // Response shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            dout  <= 1'b0;
        end else if (frame_clr) begin
            tx_sh <= '0;
            dout  <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_byte;
        end else if (sclk_fall && state != PS_DESEL) begin
            dout  <= tx_sh[BYTE_W-1];
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign dout_oe = !s_cs_n;
endmodule

// File: rtl/spi_rs_checker.sv
module spi_rs_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n_pin,
    input logic rx_valid,
    input logic dout,
    input logic dout_oe,
    input logic s_sclk,
    input logic sclk_fall,
    input logic frame_clr,
    input logic tmo,
    input logic at_boundary
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2

    AST_RX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(dout_oe)); // R3

    AST_OE_OFF_WHEN_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_pin, 2) |-> !dout_oe); // R4

    AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sclk_fall) && !$past(frame_clr)) |-> $stable(dout)); // R5

    AST_TIMEOUT_REFRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> at_boundary); // R6

    AST_HIGH_BLOCKS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_sclk) |-> !tmo); // R7
endmodule

bind spi_idle_resync_slave spi_rs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_pin    (cs_n_pin),
    .rx_valid    (rx_valid),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .s_sclk      (s_sclk),
    .sclk_fall   (sclk_fall),
    .frame_clr   (frame_clr),
    .tmo         (tmo),
    .at_boundary (at_boundary)
);

// File: tb/spi_idle_resync_slave_test.sv
module spi_idle_resync_slave_test;
    localparam int TW  = 10;
    localparam int MAXC = (1 << TW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_pin = 1'b0, cs_n_pin = 1'b1, din_pin = 1'b0;
    logic tx_load = 1'b0;
    logic [7:0] tx_byte = '0;
    logic dout, dout_oe, rx_valid;
    logic [7:0] rx_byte;

    int checks = 0, failures = 0;
    logic [7:0] got_q[$];

    always #5 clk = ~clk;

    spi_idle_resync_slave #(.BYTE_W(8), .TIMEOUT_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .cs_n_pin(cs_n_pin),
        .din_pin(din_pin), .dout(dout), .dout_oe(dout_oe), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_load(tx_load), .tx_byte(tx_byte)
    );

    // Behavioural reference: pin history, bit queue, idle counter
    logic hs[0:3], hc[0:3], hd[0:3];
    int   m_cnt;
    int   m_bits[$];
    logic m_valid, m_dout, m_oe;
    logic [7:0] m_byte, m_tx;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin hs[i] = 0; hc[i] = 1; hd[i] = 0; end
            m_cnt = 0; m_bits.delete(); m_valid = 0; m_dout = 0; m_oe = 0;
            m_byte = 0; m_tx = 0;
        end else begin
            logic c, p, cs, d, rise, fall, tmo, clr;
            for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hc[i] = hc[i-1]; hd[i] = hd[i-1]; end
            hs[0] = sclk_pin; hc[0] = cs_n_pin; hd[0] = din_pin;
            c = hs[2]; p = hs[3]; cs = hc[2]; d = hd[2];
            rise = c && !p; fall = !c && p;
            tmo = !c && (m_cnt == MAXC);
            clr = cs || tmo;
            m_cnt = c ? 0 : ((m_cnt + 1) & MAXC);
            m_valid = 0;
            if (clr) begin
                m_bits.delete(); m_dout = 0; m_tx = 0;
            end else begin
                if (rise) begin
                    m_bits.push_back(d);
                    if (m_bits.size() == 8) begin
                        for (int i = 0; i < 8; i++) m_byte[7-i] = m_bits[i][0];
                        m_valid = 1; m_bits.delete();
                    end
                end
                if (tx_load) m_tx = tx_byte;
                else if (fall) begin m_dout = m_tx[7]; m_tx = m_tx << 1; end
            end
            m_oe = !hc[1];
        end
    end

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(rx_valid == m_valid, "R2 rx_valid vs model", rx_valid, m_valid);
            if (m_valid) check(rx_byte == m_byte, "R1 rx_byte vs model", rx_byte, m_byte);
            check(dout == m_dout, "R5 dout vs model", dout, m_dout);
            check(dout_oe == m_oe, "R4 dout_oe vs model", dout_oe, m_oe);
            if (rx_valid) got_q.push_back(rx_byte);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din_pin = b; wait_n(4);
        sclk_pin = 1; wait_n(4);
        sclk_pin = 0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic [7:0] seen);
        for (int i = 7; i >= 0; i--) begin
            din_pin = v[i]; wait_n(4);
            if (i < 7) seen[i+1] = dout;
            sclk_pin = 1; wait_n(4);
            sclk_pin = 0;
        end
        wait_n(4);
        seen[0] = dout;
    endtask

    task automatic load_tx(input logic [7:0] v);
        tx_byte = v; tx_load = 1; wait_n(1); tx_load = 0; wait_n(2);
    endtask

    task automatic expect_rx(input logic [7:0] exp, input string tag);
        logic [7:0] a;
        if (got_q.size() == 0) begin
            check(0, {tag, " no byte received"}, 0, exp);
        end else begin
            a = got_q.pop_front();
            check(a == exp, tag, a, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] seen;
        wait_n(5);
        check(rx_valid == 0 && dout == 0 && dout_oe == 0, "R8 reset outputs",
              {rx_valid, dout, dout_oe}, 0);
        rst_n = 1; wait_n(4);

        // Four-wire byte with response
        cs_n_pin = 0; wait_n(6);
        check(dout_oe == 1, "R4 oe while selected", dout_oe, 1);
        load_tx(8'h3C);
        send_byte(8'hA5, seen);
        wait_n(4);
        check(got_q.size() == 1, "R2 one strobe per byte", got_q.size(), 1);
        expect_rx(8'hA5, "R1 received byte");
        check(seen == 8'h3C, "R5 response bits MSB first", seen, 8'h3C);

        // Select high mid-byte, clock edges while deselected
        send_bit(1); send_bit(1); send_bit(1);
        cs_n_pin = 1; wait_n(6);
        check(dout_oe == 0, "R4 oe off when deselected", dout_oe, 0);
        for (int i = 0; i < 9; i++) send_bit(i[0]);
        wait_n(6);
        check(got_q.size() == 0, "R3 edges ignored while deselected", got_q.size(), 0);
        cs_n_pin = 0; wait_n(6);
        send_byte(8'h5A, seen); wait_n(4);
        expect_rx(8'h5A, "R3 framing restarts after select");

        // Three-wire: glitch misaligns, idle low resynchronises
        sclk_pin = 1; wait_n(1); sclk_pin = 0; wait_n(4);
        send_byte(8'h81, seen);
        send_byte(8'h42, seen); wait_n(4);
        expect_rx(8'h40, "R6 glitch shifts first byte");
        expect_rx(8'hA1, "R6 glitch shifts second byte");
        wait_n(1100);
        send_byte(8'h99, seen); wait_n(4);
        expect_rx(8'h99, "R6 resync after low idle");

        // Timeout clears the response; repeats in a second interval
        wait_n(1500);
        load_tx(8'hFF);
        wait_n(700);
        send_byte(8'h00, seen); wait_n(4);
        check(seen == 8'h00, "R6 repeated timeout clears response", seen, 0);
        expect_rx(8'h00, "R6 byte after repeated timeout");

        // High idle does not reset framing
        send_bit(1); send_bit(1);
        din_pin = 0; wait_n(4); sclk_pin = 1; wait_n(1200); sclk_pin = 0;
        send_bit(0); send_bit(0); send_bit(0); send_bit(1); send_bit(1);
        wait_n(4);
        expect_rx(8'hC3, "R7 high idle keeps partial byte");

        // External reset mid-byte
        send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        rst_n = 0; wait_n(3);
        check(rx_valid == 0 && dout == 0 && dout_oe == 0, "R8 outputs in reset",
              {rx_valid, dout, dout_oe}, 0);
        rst_n = 1; wait_n(6);
        send_byte(8'h77, seen); wait_n(4);
        expect_rx(8'h77, "R8 partial byte dropped by reset");
        check(got_q.size() == 0, "R2 no extra strobes", got_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule